// File: doc/BRIEF.md
# Addressable Bit Latch with Readback

An eight-bit storage register that is loaded one bit at a time. A binary address picks one bit. On a rising clock edge, while the write conditions hold, the value on the single data input is stored in that bit. All stored bits are always present on a parallel output bus, so downstream logic sees every bit without having to poll it.

A parameter picks between two variants. The readback variant has a chip-enable input and a direction input. With chip enable high, the direction input either allows writes or turns the data pin around so that it drives out the addressed bit. The bidirectional pin is split into `data_i`, `data_o` and `data_oe_o`. The write-only variant ignores both chip enable and direction, and it never drives the pin. An active-low asynchronous reset clears every bit.

Top module: `bit_addr_latch`

## Requirements
- R1: Address value k (0 to NBITS-1, binary on `addr_i`) selects bit k of `q_o` as the write target.
- R2: A write is sampled only on a rising `clk_i` edge while `wr_en_ni` is low; with `wr_en_ni` high no bit changes.
- R3: In the readback variant (READBACK=1) a write also requires `ce_i` high and `wr_rd_i` high (1 = write direction); if either is low no bit changes.
- R4: In the readback variant, `ce_i` high with `wr_rd_i` low sets `data_oe_o` to 1 and `data_o` to bit `addr_i` of `q_o`, combinationally. In every other case `data_oe_o` and `data_o` are 0.
- R5: A write changes only the addressed bit; every other bit keeps its value.
- R6: `q_o` always shows the stored contents, and a read cycle leaves them unchanged.
- R7: Driving `rst_ni` low clears all bits at once, without waiting for a clock edge. It overrides any write that is set up during that time.
- R8: In the write-only variant (READBACK=0), writes depend only on `wr_en_ni`, `ce_i` and `wr_rd_i` have no effect, and `data_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears all bits |
| addr_i | input | AW (3) | Bit select |
| wr_en_ni | input | 1 | Write strobe, active low |
| ce_i | input | 1 | Chip enable (readback variant) |
| wr_rd_i | input | 1 | Direction: 1 write, 0 read (readback variant) |
| data_i | input | 1 | Serial data in |
| data_o | output | 1 | Addressed bit driven out in read mode |
| data_oe_o | output | 1 | Output enable for the data pin |
| q_o | output | NBITS (8) | Parallel view of all stored bits |

## Verification
The bench writes a one to each address in turn and then a zero to each address in turn. Unaddressed bits are thereby watched while they sit at both polarities, which exposes decode errors and writes that spill into other bits. Alternating and inverted patterns are read back at every address, which separates a correct read multiplexer from one that is stuck or shifted. Each write blocker is applied on its own: strobe high, chip enable low, direction set to read. This shows whether every gating term is really in the write path. A write-only instance receives the same stimulus and shows that chip enable and direction do nothing there. A reset asserted in the middle of a cycle, with a write set up, shows that the clear is asynchronous and takes priority over the write.

// File: rtl/bal_pkg.sv
package bal_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
  } bal_ctrl_t;
endpackage

// File: rtl/bal_decode.sv
module bal_decode #(
  parameter int NBITS = 8,
  localparam int AW = $clog2(NBITS)
) (
  input  logic [AW-1:0]    addr_i,
  output logic [NBITS-1:0] sel_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == AW'(i));
  end
endmodule

// File: rtl/bal_ctrl.sv
module bal_ctrl
  import bal_pkg::*;
#(
  parameter bit READBACK = 1'b1
) (
  input  logic      wr_en_ni,
  input  logic      ce_i,
  input  logic      wr_rd_i,
  output bal_ctrl_t ctrl_o
);
  if (READBACK) begin : g_rb
    assign ctrl_o.wr = ~wr_en_ni & ce_i & wr_rd_i;
    assign ctrl_o.rd = ce_i & ~wr_rd_i;
  end else begin : g_wo
    logic unused_w;
    assign unused_w  = ce_i ^ wr_rd_i;
    assign ctrl_o.wr = ~wr_en_ni;
    assign ctrl_o.rd = 1'b0;
  end
endmodule

// File: rtl/bal_store.sv
module bal_store #(
  parameter int NBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [NBITS-1:0] sel_i,
  input  logic             data_i,
  output logic [NBITS-1:0] q_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[i] <= 1'b0;
      else if (wr_i && sel_i[i])  q_o[i] <= data_i;
    end
  end
endmodule

// File: rtl/bal_readmux.sv
module bal_readmux #(
  parameter int NBITS = 8
) (
  input  logic             rd_i,
  input  logic [NBITS-1:0] sel_i,
  input  logic [NBITS-1:0] q_i,
  output logic             data_o,
  output logic             data_oe_o
);
  assign data_oe_o = rd_i;
  assign data_o    = rd_i & (|(q_i & sel_i));
endmodule

// File: rtl/bit_addr_latch.sv
module bit_addr_latch
  import bal_pkg::*;
#(
  parameter int NBITS    = 8,
  parameter bit READBACK = 1'b1,
  localparam int AW = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_ni,
  input  logic             ce_i,
  input  logic             wr_rd_i,
  input  logic             data_i,
  output logic             data_o,
  output logic             data_oe_o,
  output logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] sel;
  bal_ctrl_t        ctrl;

  bal_decode #(.NBITS(NBITS)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  bal_ctrl #(.READBACK(READBACK)) u_ctrl (
    .wr_en_ni (wr_en_ni),
    .ce_i     (ce_i),
    .wr_rd_i  (wr_rd_i),
    .ctrl_o   (ctrl)
  );

  bal_store #(.NBITS(NBITS)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl.wr),
    .sel_i  (sel),
    .data_i (data_i),
    .q_o    (q_o)
  );

  bal_readmux #(.NBITS(NBITS)) u_rmux (
    .rd_i      (ctrl.rd),
    .sel_i     (sel),
    .q_i       (q_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/bit_addr_latch_chk.sv
module bit_addr_latch_chk #(
  parameter int NBITS    = 8,
  parameter bit READBACK = 1'b1,
  localparam int AW = $clog2(NBITS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_ni,
  input logic             ce_i,
  input logic             wr_rd_i,
  input logic             data_i,
  input logic             data_o,
  input logic             data_oe_o,
  input logic [NBITS-1:0] q_o
);
  logic wr_ok;
  assign wr_ok = !wr_en_ni && (!READBACK || (ce_i && wr_rd_i));

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> q_o[$past(addr_i)] == $past(data_i)); // R1

  AST_STROBE_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_ni |=> $stable(q_o)); // R2

  AST_GATED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (READBACK && (!ce_i || !wr_rd_i)) |=> $stable(q_o)); // R3

  AST_ONE_BIT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q_o ^ $past(q_o)) <= 1); // R5

  AST_OE_ONLY_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (READBACK && ce_i && !wr_rd_i)); // R4

  AST_READ_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> data_o == q_o[addr_i]); // R4

  AST_WO_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !READBACK |-> !data_oe_o); // R8
endmodule

bind bit_addr_latch bit_addr_latch_chk #(.NBITS(NBITS), .READBACK(READBACK)) u_chk (.*);

// File: tb/bit_addr_latch_tb_top.sv
module bit_addr_latch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] addr = '0;
  logic       wen_n = 1'b1;
  logic       ce = 1'b0;
  logic       wr_rd = 1'b1;
  logic       din = 1'b0;
  logic       dout, doe, dout_w, doe_w;
  logic [7:0] q, q_w;
  logic [7:0] mdl, mdl_w;
  int         n_run = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_addr_latch #(.NBITS(8), .READBACK(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_ni(wen_n), .ce_i(ce),
    .wr_rd_i(wr_rd), .data_i(din), .data_o(dout), .data_oe_o(doe), .q_o(q));

  bit_addr_latch #(.NBITS(8), .READBACK(1'b0)) dut_wo_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_ni(wen_n), .ce_i(ce),
    .wr_rd_i(wr_rd), .data_i(din), .data_o(dout_w), .data_oe_o(doe_w), .q_o(q_w));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock cycle with both models; pin outputs checked before the edge, q after
  task automatic step(input logic [2:0] a, input logic d, input logic wn,
                      input logic c, input logic wr, input string req);
    logic exp_oe, exp_do;
    @(negedge clk);
    addr = a; din = d; wen_n = wn; ce = c; wr_rd = wr;
    #1;
    exp_oe = c && !wr;
    exp_do = exp_oe ? mdl[a] : 1'b0;
    chk(doe == exp_oe, {req, " R4 oe"}, int'(doe), int'(exp_oe));
    chk(dout == exp_do, {req, " R4 data"}, int'(dout), int'(exp_do));
    chk(doe_w == 1'b0, {req, " R8 oe"}, int'(doe_w), 0);
    if (!wn && c && wr) mdl[a] = d;
    if (!wn) mdl_w[a] = d;
    @(posedge clk); #1;
    chk(q == mdl, {req, " q"}, int'(q), int'(mdl));
    chk(q_w == mdl_w, {req, " R8 q"}, int'(q_w), int'(mdl_w));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; #3;
    mdl = '0; mdl_w = '0;
    chk(q == 8'h00, "R7 reset", int'(q), 0);
    chk(q_w == 8'h00, "R7 reset wo", int'(q_w), 0);
    chk(doe == 1'b0, "R4 reset oe", int'(doe), 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_walk();
    for (int i = 0; i < 8; i++) step(3'(i), 1'b1, 1'b0, 1'b1, 1'b1, "R1 R5 walk1");
    chk(q == 8'hFF, "R1 all ones", int'(q), 8'hFF);
    for (int i = 0; i < 8; i++) step(3'(i), 1'b0, 1'b0, 1'b1, 1'b1, "R1 R5 walk0");
    chk(q == 8'h00, "R5 all zeros", int'(q), 0);
  endtask

  task automatic t_pattern_read(input logic [7:0] pat);
    for (int i = 0; i < 8; i++) step(3'(i), pat[i], 1'b0, 1'b1, 1'b1, "R1 pattern");
    for (int i = 7; i >= 0; i--) step(3'(i), ~pat[i], 1'b0, 1'b1, 1'b0, "R4 R6 read");
    chk(q == pat, "R6 after read", int'(q), int'(pat));
  endtask

  task automatic t_blockers();
    step(3'd3, ~mdl[3], 1'b1, 1'b1, 1'b1, "R2 strobe high");
    step(3'd4, ~mdl[4], 1'b0, 1'b0, 1'b1, "R3 ce low");
    step(3'd5, ~mdl[5], 1'b0, 1'b1, 1'b0, "R3 read dir");
    step(3'd6, ~mdl[6], 1'b0, 1'b0, 1'b0, "R3 R8 ce low read");
    step(3'd2, ~mdl[2], 1'b1, 1'b0, 1'b0, "R4 idle");
  endtask

  task automatic t_reset_mid();
    step(3'd1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 preload");
    @(negedge clk);
    addr = 3'd0; din = 1'b1; wen_n = 1'b0; ce = 1'b1; wr_rd = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    chk(q == 8'h00, "R7 async clear", int'(q), 0);
    chk(q_w == 8'h00, "R7 async clear wo", int'(q_w), 0);
    @(posedge clk); #1;
    chk(q == 8'h00, "R7 priority", int'(q), 0);
    mdl = '0; mdl_w = '0;
    @(negedge clk); rst_n = 1'b1; wen_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    mdl = '0; mdl_w = '0;
    t_reset();
    t_walk();
    t_pattern_read(8'hA5);
    t_pattern_read(8'h5A);
    t_blockers();
    t_pattern_read(8'h3C);
    t_reset_mid();
    step(3'd7, 1'b1, 1'b0, 1'b1, 1'b0, "R8 wo ignores dir");
    step(3'd7, 1'b0, 1'b0, 1'b1, 1'b0, "R4 read after wo write");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule